// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a write-only two-wire serial bus target that owns a small bank of 8-bit configuration registers and decides where the configuration comes from. Both bus lines are oversampled in the system clock domain. Start, repeated start and stop conditions are found from edges of the synchronized lines. A transaction carries three bytes, each sent most significant bit first: a device address byte, a register pointer and one data byte. The block acknowledges each byte by pulling SDA low through an open-drain pad enable.

Out of reset, the configuration outputs come from parallel strap pins, and from built-in defaults for registers that have no pin. The first write that hits this device's address hands control to the serial register bank for good. From then on the pins are ignored until the next reset. The device address is the fixed pattern 1001 above three strap inputs.

The controller has eight states. IDLE waits for a start. DEV shifts in the address byte, then moves to DEV_ACK on a match or to IGNORE on a miss. DEV_ACK moves to PTR on the next SCL fall. PTR shifts in the pointer and moves to PTR_ACK. PTR_ACK moves to DATA on the next SCL fall. DATA shifts in the data byte, commits it and moves to DATA_ACK. DATA_ACK moves to IGNORE on the next SCL fall. IGNORE waits for the bus. From any state, a stop leads to IDLE and a start or repeated start leads to DEV with the bit count cleared.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, serial_mode_o is 0 and sda_pull_o is 0. Registers 2 and 3 read their defaults, and registers 0 and 1 show the pins. Byte i of cfg_o is register i, and pin_cfg[7:0] belongs to register 0.
- R2: While serial_mode_o is 0, cfg_o[15:0] equals pin_cfg and follows every change of the pins.
- R3: The address byte is accepted only if its upper seven bits equal {4'b1001, addr_strap} and bit 0 (R/W) is 0. With strap 3'b010 the accepted byte is 0x94. A mismatch, or a byte with R/W set to 1, gets no acknowledge, changes no register and leaves the control source unchanged.
- R4: For each accepted byte, sda_pull_o rises after the SCL fall that ends bit 8. It stays high through the acknowledge clock and drops after the next SCL fall.
- R5: The data byte is stored in the register selected by the pointer. It is visible on cfg_o after the SCL fall of its eighth bit and before the acknowledge clock rises.
- R6: An address-matched write sets serial_mode_o, and the flag stays set until reset. After that point, registers 0 and 1 keep the pin values they held at takeover unless they are written, and later pin changes have no effect on cfg_o.
- R7: A pointer of 4 or more is acknowledged, along with its data byte, but no register changes.
- R8: A repeated start after the data acknowledge begins a new address phase, and a second write in that phase takes effect.
- R9: A stop in the middle of a data byte ends the transaction with no register change.
- R10: Register 2 (default 0x81) and register 3 (default 0x5A) have no pins. They keep their defaults until they are written serially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 3 | Low three bits of the device address |
| pin_cfg | input | 16 | Parallel configuration pins for registers 0 and 1 |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| serial_mode_o | output | 1 | High once serial control has taken over |
| cfg_o | output | 32 | Configuration outputs, one byte per register |

## Verification
A wrong bit count or state shows up at the ports within one byte. Either sda_pull_o misses its window on the acknowledge clock, or the data byte lands in cfg_o in the wrong cycle or the wrong register. A wrongly held control-source flag shows up at the next pin change: cfg_o either fails to follow the pins or follows them after takeover. Each scenario therefore probes cfg_o between the eighth data fall and the acknowledge rise, and it probes again after moving the pins.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int DEV_W     = 7;
    localparam int STRAP_W   = 3;
    localparam logic [DEV_W-STRAP_W-1:0] ADDR_FIXED = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } st_e;
endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & ~sda_s & sda_d;
    assign stop_det  = scl_now & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/cfgslv_fsm.sv
module cfgslv_fsm
    import cfgslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DEV_W-1:0]  dev_addr,
    output logic              ack_o,
    output logic              take_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    st_e               state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic [BYTE_W-1:0] ptr_q, ptr_n;
    logic              shift_st;
    logic              byte_done;
    logic              dev_hit;

    assign shift_st  = (state_q == ST_DEV) || (state_q == ST_PTR) || (state_q == ST_DATA);
    assign byte_done = shift_st && scl_fall && (cnt_q == CNT_W'(BYTE_W));
    assign dev_hit   = (sh_q[BYTE_W-1:1] == dev_addr) && !sh_q[0];

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        ptr_n   = ptr_q;
        take_o  = 1'b0;
        wr_en_o = 1'b0;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_DEV;
            cnt_n   = '0;
        end else begin
            if (shift_st && scl_rise) begin
                sh_n  = {sh_q[BYTE_W-2:0], sda_s};
                cnt_n = cnt_q + 1'b1;
            end
            unique case (state_q)
                ST_IDLE: ;
                ST_IGNORE: ;
                ST_DEV: begin
                    if (byte_done) begin
                        if (dev_hit) begin
                            state_n = ST_DEV_ACK;
                            take_o  = 1'b1;
                        end else begin
                            state_n = ST_IGNORE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        state_n = ST_PTR;
                        cnt_n   = '0;
                    end
                end
                ST_PTR: begin
                    if (byte_done) begin
                        ptr_n   = sh_q;
                        state_n = ST_PTR_ACK;
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        wr_en_o = 1'b1;
                        state_n = ST_DATA_ACK;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) state_n = ST_IGNORE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            ptr_q   <= ptr_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
        end else begin
            ack_o <= (state_n == ST_DEV_ACK) || (state_n == ST_PTR_ACK) ||
                     (state_n == ST_DATA_ACK);
        end
    end

    assign wr_addr_o = ptr_q;
    assign wr_data_o = sh_q;
endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS     = 4,
    parameter int NUM_PIN_REGS = 2,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take,
    input  logic                           wr_en,
    input  logic [BYTE_W-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic [NUM_PIN_REGS*BYTE_W-1:0] pin_cfg,
    output logic                           serial_mode,
    output logic [NUM_REGS*BYTE_W-1:0]     cfg_o
);
    logic [BYTE_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) serial_mode <= 1'b0;
        else if (take) serial_mode <= 1'b1;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_addr == BYTE_W'(i));
        if (i < NUM_PIN_REGS) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs[i] <= DEFAULTS[i*BYTE_W +: BYTE_W];
                else if (hit) regs[i] <= wr_data;
                else if (!serial_mode) regs[i] <= pin_cfg[i*BYTE_W +: BYTE_W];
            end
            assign cfg_o[i*BYTE_W +: BYTE_W] =
                serial_mode ? regs[i] : pin_cfg[i*BYTE_W +: BYTE_W];
        end else begin : g_soft
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs[i] <= DEFAULTS[i*BYTE_W +: BYTE_W];
                else if (hit) regs[i] <= wr_data;
            end
            assign cfg_o[i*BYTE_W +: BYTE_W] = regs[i];
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS     = 4,
    parameter int NUM_PIN_REGS = 2,
    parameter int SYNC_STAGES  = 2,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 32'h5A81_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_i,
    input  logic                           sda_i,
    input  logic [STRAP_W-1:0]             addr_strap,
    input  logic [NUM_PIN_REGS*BYTE_W-1:0] pin_cfg,
    output logic                           sda_pull_o,
    output logic                           serial_mode_o,
    output logic [NUM_REGS*BYTE_W-1:0]     cfg_o
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              take;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [DEV_W-1:0]  dev_addr;

    assign dev_addr = {ADDR_FIXED, addr_strap};

    cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgslv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .ack_o     (sda_pull_o),
        .take_o    (take),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    cfgslv_regfile #(
        .NUM_REGS     (NUM_REGS),
        .NUM_PIN_REGS (NUM_PIN_REGS),
        .DEFAULTS     (DEFAULTS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pin_cfg     (pin_cfg),
        .serial_mode (serial_mode_o),
        .cfg_o       (cfg_o)
    );
endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
    parameter int NUM_REGS     = 4,
    parameter int NUM_PIN_REGS = 2,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_i,
    input logic                    sda_pull_o,
    input logic                    serial_mode_o,
    input logic                    wr_en,
    input logic [NUM_PIN_REGS*8-1:0] pin_cfg,
    input logic [NUM_REGS*8-1:0]   cfg_o
);
    localparam int PIN_W = NUM_PIN_REGS * 8;
    localparam int ALL_W = NUM_REGS * 8;

    p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode_o |=> serial_mode_o);

    p_pins_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode_o && $past(serial_mode_o) && !$past(wr_en)) |-> $stable(cfg_o));

    p_write_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> serial_mode_o);

    p_take_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serial_mode_o) |-> sda_pull_o);

    p_par_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode_o |-> (cfg_o[PIN_W-1:0] == pin_cfg));

    p_ack_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    p_ack_end_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_i);

    if (NUM_PIN_REGS < NUM_REGS) begin : g_soft
        p_soft_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !serial_mode_o |-> (cfg_o[ALL_W-1:PIN_W] == DEFAULTS[ALL_W-1:PIN_W]));
    end
endmodule

bind cfg_i2c_slave cfgslv_chk #(
    .NUM_REGS     (NUM_REGS),
    .NUM_PIN_REGS (NUM_PIN_REGS),
    .DEFAULTS     (DEFAULTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_pull_o    (sda_pull_o),
    .serial_mode_o (serial_mode_o),
    .wr_en         (wr_en),
    .pin_cfg       (pin_cfg),
    .cfg_o         (cfg_o)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b010;
    logic [15:0] pins = 16'h1234;
    logic        sda_pull;
    logic        ser_mode;
    logic [31:0] cfg;
    logic        sda_bus;
    logic [7:0]  er [4];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    cfg_i2c_slave u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_bus),
        .addr_strap    (strap),
        .pin_cfg       (pins),
        .sda_pull_o    (sda_pull),
        .serial_mode_o (ser_mode),
        .cfg_o         (cfg)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wait(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] expect_cfg();
        if (ser_mode) return {er[3], er[2], er[1], er[0]};
        return {8'h5A, 8'h81, pins};
    endfunction

    task automatic start_c();
        sda_m = 1'b1; bus_wait(Q);
        scl = 1'b1; bus_wait(Q);
        sda_m = 1'b0; bus_wait(Q);
        scl = 1'b0; bus_wait(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; bus_wait(Q);
        scl = 1'b1; bus_wait(Q);
        sda_m = 1'b1; bus_wait(2 * Q);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; bus_wait(Q);
            scl = 1'b1; bus_wait(2 * Q);
            scl = 1'b0; bus_wait(Q);
        end
    endtask

    task automatic ack_clock(output logic got, output logic held, output logic rel);
        sda_m = 1'b1; bus_wait(Q);
        scl = 1'b1; bus_wait(Q);
        got = ~sda_bus; held = sda_pull;
        bus_wait(Q);
        scl = 1'b0; bus_wait(Q);
        rel = ~sda_pull;
    endtask

    task automatic byte_acked(string req, logic [7:0] b, logic want);
        logic g, h, r;
        send_bits(b, 8);
        ack_clock(g, h, r);
        check(req, "ack seen on bus", 32'(g), 32'(want));
        if (want) begin
            check("R4", "pull held in ack clock", 32'(h), 32'd1);
            check("R4", "pull released after ack", 32'(r), 32'd1);
        end
    endtask

    task automatic t_reset_state();
        check("R1", "serial mode after reset", 32'(ser_mode), 32'd0);
        check("R1", "sda pull after reset", 32'(sda_pull), 32'd0);
        check("R1", "cfg after reset", cfg, {8'h5A, 8'h81, 16'h1234});
    endtask

    task automatic t_parallel_follow();
        pins = 16'hBEEF; bus_wait(2);
        check("R2", "cfg follows pins", cfg, {8'h5A, 8'h81, 16'hBEEF});
        pins = 16'h0F0F; bus_wait(2);
        check("R2", "cfg follows pins again", cfg, {8'h5A, 8'h81, 16'h0F0F});
    endtask

    task automatic t_addr_reject();
        start_c(); byte_acked("R3", 8'h96, 1'b0); stop_c();
        check("R3", "mode after wrong address", 32'(ser_mode), 32'd0);
        start_c(); byte_acked("R3", 8'h95, 1'b0); stop_c();
        check("R3", "mode after read request", 32'(ser_mode), 32'd0);
        check("R3", "cfg untouched", cfg, {8'h5A, 8'h81, 16'h0F0F});
    endtask

    task automatic t_first_write();
        logic g, h, r;
        er[0] = pins[7:0]; er[1] = pins[15:8]; er[2] = 8'h81; er[3] = 8'h5A;
        start_c();
        byte_acked("R3", 8'h94, 1'b1);
        check("R6", "mode set by matched write", 32'(ser_mode), 32'd1);
        byte_acked("R4", 8'h02, 1'b1);
        send_bits(8'hA5, 8);
        er[2] = 8'hA5;
        check("R5", "data visible before ack clock", cfg, expect_cfg());
        ack_clock(g, h, r);
        check("R4", "data ack", 32'(g & h & r), 32'd1);
        stop_c();
        check("R10", "soft reg written", 32'(cfg[23:16]), 32'hA5);
        check("R6", "pin regs kept at takeover", 32'(cfg[15:0]), 32'h0F0F);
    endtask

    task automatic t_pins_ignored();
        pins = 16'h7777; bus_wait(4);
        check("R6", "pins ignored after takeover", cfg, expect_cfg());
        check("R6", "mode sticky", 32'(ser_mode), 32'd1);
    endtask

    task automatic t_rstart_pair();
        start_c();
        byte_acked("R8", 8'h94, 1'b1);
        byte_acked("R8", 8'h00, 1'b1);
        byte_acked("R8", 8'h3C, 1'b1);
        er[0] = 8'h3C;
        start_c();
        byte_acked("R8", 8'h94, 1'b1);
        byte_acked("R8", 8'h01, 1'b1);
        byte_acked("R8", 8'hC3, 1'b1);
        er[1] = 8'hC3;
        stop_c();
        check("R8", "both writes landed", cfg, expect_cfg());
    endtask

    task automatic t_bad_ptr();
        start_c();
        byte_acked("R7", 8'h94, 1'b1);
        byte_acked("R7", 8'h07, 1'b1);
        byte_acked("R7", 8'hEE, 1'b1);
        stop_c();
        check("R7", "out of range pointer no change", cfg, expect_cfg());
    endtask

    task automatic t_abort();
        start_c();
        byte_acked("R9", 8'h94, 1'b1);
        byte_acked("R9", 8'h03, 1'b1);
        send_bits(8'hFF, 4);
        stop_c();
        check("R9", "aborted byte not written", cfg, expect_cfg());
    endtask

    task automatic t_strap_change();
        strap = 3'b101; bus_wait(2);
        start_c(); byte_acked("R3", 8'h94, 1'b0); stop_c();
        start_c();
        byte_acked("R3", 8'h9A, 1'b1);
        byte_acked("R3", 8'h03, 1'b1);
        byte_acked("R3", 8'h66, 1'b1);
        stop_c();
        er[3] = 8'h66;
        check("R3", "write via new strap", cfg, expect_cfg());
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0; bus_wait(3);
        rst_n = 1'b1; bus_wait(3);
        check("R1", "mode cleared by reset", 32'(ser_mode), 32'd0);
        check("R10", "defaults restored", cfg, {8'h5A, 8'h81, 16'h7777});
        pins = 16'h4242; bus_wait(2);
        check("R2", "pins followed after reset", cfg, {8'h5A, 8'h81, 16'h4242});
    endtask

    initial begin
        bus_wait(5);
        rst_n = 1'b1;
        bus_wait(5);
        t_reset_state();
        t_parallel_follow();
        t_addr_reject();
        t_first_write();
        t_pins_ignored();
        t_rstart_pair();
        t_bad_ptr();
        t_abort();
        t_strap_change();
        t_reset_again();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-reqs: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule